// File: doc/BRIEF.md
# Atomic Memory and Stack Unit

This block carries out the memory-side half of a small processor's instructions against a single-port, word-addressed RAM. It performs plain loads and stores, two indivisible read-modify-write operations (swap and fetch-and-add), and the stack operations: push a register, push a computed address, pop to a register, discard the top of the stack, subroutine call and return. The block owns the stack pointer. Instruction parsing and the general register file sit outside it.

A request supplies an opcode, an immediate, two base operands with their register selects, a source value and the current program counter. The effective address is the immediate plus both base operands. A select of zero marks the hidden always-zero register, and that slot then adds nothing whatever value is presented. Every request takes exactly two cycles. `busy` is high for both, `done` marks the second, and the response (old memory word, new stack pointer, new program counter) is valid while `done` is high. The RAM port is held by the operation for both cycles, so the read and write of a swap or fetch-and-add are never split by another access.

Top module: `ms_top`

## Requirements
- R1: After reset `busy`, `done`, `mem_en` and `rsp_pc_load` are low and `rsp_sp` equals the parameter SP_INIT (default 512).
- R2: The effective address is `req_imm + val_a + val_b`, truncated to ADDR_W bits, with wraparound, so a negative immediate counts down. It is used by load (opcode 0) and store (opcode 1). A store writes `req_src`, and a load returns the addressed word on `rsp_data`.
- R3: A register select of 0 on either base slot makes that slot contribute zero regardless of its value input.
- R4: Swap (opcode 2) reads the addressed word, writes `req_src` there in the next cycle, and returns the old word on `rsp_data`.
- R5: Fetch-and-add (opcode 3) reads the addressed word, writes old+`req_src` there in the next cycle, and returns the old word.
- R6: Push (opcode 4) lowers the stack pointer by STEP (default 4) and writes `req_src` at the new stack pointer.
- R7: Push-address (opcode 5) lowers the stack pointer by STEP and writes the effective address itself, not the memory contents, at the new stack pointer.
- R8: Pop (opcode 6) returns the word at the stack pointer and raises the stack pointer by STEP. Discard (opcode 7) only raises the stack pointer by STEP: it makes no RAM access and returns zero.
- R9: Call (opcode 8) lowers the stack pointer by STEP, stores `req_pc` at the new stack pointer, and returns `req_imm` on `rsp_pc` with `rsp_pc_load` high. Return (opcode 9) loads `rsp_pc` from the word at the stack pointer, raises the stack pointer by STEP, and asserts `rsp_pc_load`.
- R10: A request is taken only while `busy` is low. `busy` stays high for exactly two cycles and `done` is high in the second. A request presented while busy is ignored.
- R11: Opcodes 10 to 15 make no RAM access, leave the stack pointer unchanged, return zero and still complete in two cycles.
- R12: The stack pointer changes only in the cycle a request is taken, and the RAM port is idle whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code |
| req_imm | input | DATA_W | Immediate offset, or call target |
| req_sel_a | input | SEL_W | Register select of first base (0 = zero register) |
| req_val_a | input | DATA_W | Value of first base register |
| req_sel_b | input | SEL_W | Register select of second base (0 = zero register) |
| req_val_b | input | DATA_W | Value of second base register |
| req_src | input | DATA_W | Source register value |
| req_pc | input | DATA_W | Program counter to save on call |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle; response valid |
| rsp_data | output | DATA_W | Old memory word / popped word |
| rsp_sp | output | ADDR_W | Current stack pointer |
| rsp_pc | output | DATA_W | New program counter |
| rsp_pc_load | output | 1 | `rsp_pc` must be loaded |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after a read |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after an enabled read, and that requests are presented only through `req_valid` against the `busy` flag. The bench's RAM model has that one-cycle latency, and the bench drives every field on the falling edge. In one scenario it holds `req_valid` high through a busy window, to show that the extra request is dropped rather than queued. Stack traffic stays inside the model's address range: the pointer starts at 512 and moves only a few words.

// File: rtl/ms_pkg.sv
package ms_pkg;
   typedef enum logic [3:0] {
      OP_LOAD  = 4'd0,
      OP_STORE = 4'd1,
      OP_SWAP  = 4'd2,
      OP_FADD  = 4'd3,
      OP_PUSH  = 4'd4,
      OP_PUSHA = 4'd5,
      OP_POP   = 4'd6,
      OP_DROP  = 4'd7,
      OP_CALL  = 4'd8,
      OP_RET   = 4'd9
   } ms_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_FIN  = 2'd2
   } ms_state_e;

   function automatic logic op_is_rmw(input logic [3:0] op);
      return (op == OP_SWAP) || (op == OP_FADD);
   endfunction

   function automatic logic op_grows(input logic [3:0] op);
      return (op == OP_PUSH) || (op == OP_PUSHA) || (op == OP_CALL);
   endfunction

   function automatic logic op_shrinks(input logic [3:0] op);
      return (op == OP_POP) || (op == OP_DROP) || (op == OP_RET);
   endfunction

   function automatic logic op_writes_first(input logic [3:0] op);
      return (op == OP_STORE) || op_grows(op);
   endfunction

   function automatic logic op_uses_ram(input logic [3:0] op);
      return (op <= 4'd9) && (op != OP_DROP);
   endfunction

   function automatic logic op_returns_word(input logic [3:0] op);
      return (op == OP_LOAD) || (op == OP_POP) || op_is_rmw(op);
   endfunction
endpackage

// File: rtl/ms_agen.sv
module ms_agen #(
   parameter int DATA_W   = 32,
   parameter int SEL_W    = 3,
   parameter int BASE_CNT = 2
) (
   input  logic [DATA_W-1:0] imm,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic [DATA_W-1:0] val_a,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic [DATA_W-1:0] val_b,
   output logic [DATA_W-1:0] ea
);
   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] opnd_b;

   assign opnd_a = (sel_a == '0) ? '0 : val_a;

   generate
      if (BASE_CNT == 2) begin : g_two_base
         assign opnd_b = (sel_b == '0) ? '0 : val_b;
      end else if (BASE_CNT == 1) begin : g_one_base
         logic unused_b;
         assign unused_b = ^{sel_b, val_b};
         assign opnd_b = '0;
      end else begin : g_bad_base
         $error("ms_agen: BASE_CNT must be 1 or 2");
         assign opnd_b = '0;
      end
   endgenerate

   assign ea = imm + opnd_a + opnd_b;
endmodule

// File: rtl/ms_stack.sv
module ms_stack #(
   parameter int ADDR_W = 10,
   parameter int STEP   = 4,
   parameter logic [ADDR_W-1:0] SP_INIT = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              step_down,
   output logic [ADDR_W-1:0] sp_q,
   output logic [ADDR_W-1:0] sp_lowered
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   assign sp_lowered = sp_q - STEP_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_INIT;
      end else if (step_en) begin
         sp_q <= step_down ? sp_lowered : (sp_q + STEP_V);
      end
   end
endmodule

// File: rtl/ms_merge.sv
module ms_merge #(
   parameter int DATA_W = 32
) (
   input  logic [3:0]        op,
   input  logic              fin,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] held,
   input  logic [DATA_W-1:0] target,
   output logic [DATA_W-1:0] rmw_wdata,
   output logic [DATA_W-1:0] rsp_data,
   output logic [DATA_W-1:0] rsp_pc,
   output logic              rsp_pc_load
);
   import ms_pkg::*;

   always_comb begin
      rmw_wdata   = (op == OP_FADD) ? (rdata + held) : held;
      rsp_data    = '0;
      rsp_pc      = '0;
      rsp_pc_load = 1'b0;
      if (fin) begin
         if (op_returns_word(op)) rsp_data = rdata;
         if (op == OP_CALL) begin
            rsp_pc      = target;
            rsp_pc_load = 1'b1;
         end else if (op == OP_RET) begin
            rsp_pc      = rdata;
            rsp_pc_load = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ms_top.sv
module ms_top #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter int SEL_W    = 3,
   parameter int BASE_CNT = 2,
   parameter int STEP     = 4,
   parameter int SP_INIT  = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_op,
   input  logic [DATA_W-1:0] req_imm,
   input  logic [SEL_W-1:0]  req_sel_a,
   input  logic [DATA_W-1:0] req_val_a,
   input  logic [SEL_W-1:0]  req_sel_b,
   input  logic [DATA_W-1:0] req_val_b,
   input  logic [DATA_W-1:0] req_src,
   input  logic [DATA_W-1:0] req_pc,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] rsp_sp,
   output logic [DATA_W-1:0] rsp_pc,
   output logic              rsp_pc_load,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   import ms_pkg::*;

   localparam logic [ADDR_W-1:0] SP_INIT_V = ADDR_W'(SP_INIT);

   if (ADDR_W > DATA_W) begin : g_chk_addr
      $error("ms_top: ADDR_W must not exceed DATA_W");
   end
   if (STEP < 1) begin : g_chk_step
      $error("ms_top: STEP must be positive");
   end

   ms_state_e         state_q;
   logic              accept;
   logic [DATA_W-1:0] ea;
   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] sp_lowered;
   logic [3:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] held_q;
   logic [DATA_W-1:0] target_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic [DATA_W-1:0] held_nxt;
   logic [DATA_W-1:0] rmw_wdata;
   logic              in_act;
   logic              in_fin;

   assign busy   = (state_q != ST_IDLE);
   assign accept = req_valid && !busy;
   assign in_act = (state_q == ST_ACT);
   assign in_fin = (state_q == ST_FIN);
   assign done   = in_fin;

   ms_agen #(
      .DATA_W(DATA_W), .SEL_W(SEL_W), .BASE_CNT(BASE_CNT)
   ) u_agen (
      .imm(req_imm), .sel_a(req_sel_a), .val_a(req_val_a),
      .sel_b(req_sel_b), .val_b(req_val_b), .ea(ea)
   );

   ms_stack #(
      .ADDR_W(ADDR_W), .STEP(STEP), .SP_INIT(SP_INIT_V)
   ) u_stack (
      .clk(clk), .rst_n(rst_n),
      .step_en(accept && (op_grows(req_op) || op_shrinks(req_op))),
      .step_down(op_grows(req_op)),
      .sp_q(sp_q), .sp_lowered(sp_lowered)
   );

   always_comb begin
      if (op_grows(req_op))        addr_nxt = sp_lowered;
      else if (op_shrinks(req_op)) addr_nxt = sp_q;
      else                         addr_nxt = ea[ADDR_W-1:0];
      case (req_op)
         OP_PUSHA: held_nxt = ea;
         OP_CALL:  held_nxt = req_pc;
         default:  held_nxt = req_src;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         op_q     <= 4'hF;
         addr_q   <= '0;
         held_q   <= '0;
         target_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) state_q <= ST_ACT;
            ST_ACT:  state_q <= ST_FIN;
            default: state_q <= ST_IDLE;
         endcase
         if (accept) begin
            op_q     <= req_op;
            addr_q   <= addr_nxt;
            held_q   <= held_nxt;
            target_q <= req_imm;
         end
      end
   end

   ms_merge #(.DATA_W(DATA_W)) u_merge (
      .op(op_q), .fin(in_fin), .rdata(mem_rdata), .held(held_q),
      .target(target_q), .rmw_wdata(rmw_wdata), .rsp_data(rsp_data),
      .rsp_pc(rsp_pc), .rsp_pc_load(rsp_pc_load)
   );

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = addr_q;
      mem_wdata = held_q;
      if (in_act) begin
         mem_en = op_uses_ram(op_q);
         mem_we = op_writes_first(op_q);
      end else if (in_fin && op_is_rmw(op_q)) begin
         mem_en    = 1'b1;
         mem_we    = 1'b1;
         mem_wdata = rmw_wdata;
      end
   end

   assign rsp_sp = sp_q;
endmodule

// File: rtl/ms_chk.sv
module ms_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] rsp_sp,
   input logic              rsp_pc_load,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   // R10: completion only inside a busy window
   assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R10: first cycle after acceptance is busy without done
   assert_first_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> (busy && !done));

   // R10: completion exactly two cycles after acceptance
   assert_two_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> ##1 done);

   // R4 R5: atomic write follows a read of the same word
   assert_rmw_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mem_en && mem_we) |-> ($past(mem_en && !mem_we) && (mem_addr == $past(mem_addr))));

   // R12: RAM idle when not busy
   assert_port_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_en);

   // R12: stack pointer moves only on acceptance
   assert_sp_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !busy) |=> $stable(rsp_sp));

   // R9: program counter load only at completion
   assert_pc_load_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pc_load |-> done);
endmodule

bind ms_top ms_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ms_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
   .rsp_sp(rsp_sp), .rsp_pc_load(rsp_pc_load), .mem_en(mem_en),
   .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/ms_top_tb_top.sv
module ms_top_tb_top;
   localparam int DW = 32;
   localparam int AW = 10;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_op = '0;
   logic [DW-1:0] req_imm = '0, req_val_a = '0, req_val_b = '0, req_src = '0, req_pc = '0;
   logic [SW-1:0] req_sel_a = '0, req_sel_b = '0;
   logic          busy, done, rsp_pc_load, mem_en, mem_we;
   logic [DW-1:0] rsp_data, rsp_pc, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] rsp_sp, mem_addr;

   logic [DW-1:0] ram [0:(1<<AW)-1];
   int            n_checks = 0;
   int            n_fail = 0;
   int            ram_hits = 0;
   logic [DW-1:0] got_data, got_pc;
   logic          got_load;
   logic [AW-1:0] exp_sp;
   bit            finished = 0;

   always #4 clk = ~clk;

   ms_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_imm(req_imm), .req_sel_a(req_sel_a), .req_val_a(req_val_a),
      .req_sel_b(req_sel_b), .req_val_b(req_val_b), .req_src(req_src),
      .req_pc(req_pc), .busy(busy), .done(done), .rsp_data(rsp_data),
      .rsp_sp(rsp_sp), .rsp_pc(rsp_pc), .rsp_pc_load(rsp_pc_load),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         ram_hits <= ram_hits + 1;
         if (mem_we) ram[mem_addr] <= mem_wdata;
         mem_rdata <= ram[mem_addr];
      end
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [DW-1:0] imm,
                         input logic [SW-1:0] sa, input logic [DW-1:0] va,
                         input logic [SW-1:0] sb, input logic [DW-1:0] vb,
                         input logic [DW-1:0] src, input logic [DW-1:0] pc);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_imm = imm; req_sel_a = sa; req_val_a = va;
      req_sel_b = sb; req_val_b = vb; req_src = src; req_pc = pc;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && !done, "R10 first cycle busy", {busy, done}, 2'b10);
      @(negedge clk);
      chk(busy && done, "R10 second cycle done", {busy, done}, 2'b11);
      got_data = rsp_data; got_pc = rsp_pc; got_load = rsp_pc_load;
      chk(rsp_sp == exp_sp, "R12 stack pointer", rsp_sp, exp_sp);
      @(negedge clk);
      chk(!busy, "R10 idle after done", busy, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !mem_en && !rsp_pc_load, "R1 reset flags",
          {busy, done, mem_en, rsp_pc_load}, 0);
      chk(rsp_sp == 512, "R1 reset stack pointer", rsp_sp, 512);
   endtask

   task automatic t_addr();
      run_op(4'd1, 32'd10, 3'd1, 32'd5, 3'd0, 32'd999, 32'hA5A5, 0);
      chk(ram[15] == 32'hA5A5, "R3 zero select ignores value", ram[15], 32'hA5A5);
      run_op(4'd0, 32'd3, 3'd2, 32'd4, 3'd3, 32'd8, 0, 0);
      chk(got_data == 32'hA5A5, "R2 two bases load", got_data, 32'hA5A5);
      run_op(4'd0, 32'hFFFF_FFFB, 3'd0, 32'd7, 3'd4, 32'd20, 0, 0);
      chk(got_data == 32'hA5A5, "R2 negative immediate", got_data, 32'hA5A5);
   endtask

   task automatic t_swap();
      run_op(4'd2, 32'd15, 3'd0, 0, 3'd0, 0, 32'h1111, 0);
      chk(got_data == 32'hA5A5, "R4 swap old word", got_data, 32'hA5A5);
      chk(ram[15] == 32'h1111, "R4 swap new word", ram[15], 32'h1111);
   endtask

   task automatic t_fadd();
      run_op(4'd3, 32'd5, 3'd5, 32'd10, 3'd0, 0, 32'h22, 0);
      chk(got_data == 32'h1111, "R5 fetch-add old word", got_data, 32'h1111);
      chk(ram[15] == 32'h1133, "R5 fetch-add sum", ram[15], 32'h1133);
   endtask

   task automatic t_push();
      exp_sp = 508;
      run_op(4'd4, 0, 3'd0, 0, 3'd0, 0, 32'hBEEF, 0);
      chk(ram[508] == 32'hBEEF, "R6 push stores source", ram[508], 32'hBEEF);
      exp_sp = 504;
      ram[42] = 32'hDEAD;
      run_op(4'd5, 32'd40, 3'd1, 32'd2, 3'd0, 0, 32'h5555, 0);
      chk(ram[504] == 32'd42, "R7 push-address stores address", ram[504], 32'd42);
   endtask

   task automatic t_pop();
      int hits0;
      exp_sp = 508;
      run_op(4'd6, 0, 3'd0, 0, 3'd0, 0, 0, 0);
      chk(got_data == 32'd42, "R8 pop word", got_data, 32'd42);
      exp_sp = 512;
      hits0 = ram_hits;
      run_op(4'd7, 0, 3'd0, 0, 3'd0, 0, 0, 0);
      chk(got_data == 0, "R8 discard returns zero", got_data, 0);
      chk(ram_hits == hits0, "R8 discard no RAM access", ram_hits - hits0, 0);
      chk(ram[508] == 32'hBEEF, "R8 discard leaves RAM", ram[508], 32'hBEEF);
   endtask

   task automatic t_call_ret();
      exp_sp = 508;
      run_op(4'd8, 32'd77, 3'd0, 0, 3'd0, 0, 0, 32'd33);
      chk(got_load && got_pc == 32'd77, "R9 call target", got_pc, 32'd77);
      chk(ram[508] == 32'd33, "R9 call saves pc", ram[508], 32'd33);
      exp_sp = 512;
      run_op(4'd9, 0, 3'd0, 0, 3'd0, 0, 0, 0);
      chk(got_load && got_pc == 32'd33, "R9 return pc", got_pc, 32'd33);
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      req_valid = 1'b1; req_op = 4'd1; req_imm = 32'd100; req_sel_a = 0; req_sel_b = 0; req_src = 32'h77;
      @(negedge clk);
      req_imm = 32'd300; req_src = 32'h99;
      @(negedge clk);
      chk(done, "R10 done while request held", done, 1);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(ram[100] == 32'h77, "R10 first request stored", ram[100], 32'h77);
      chk(ram[300] == 0, "R10 request during busy ignored", ram[300], 0);
   endtask

   task automatic t_illegal();
      int hits0;
      hits0 = ram_hits;
      exp_sp = 512;
      run_op(4'd12, 32'd15, 3'd0, 0, 3'd0, 0, 32'h1, 0);
      chk(ram_hits == hits0, "R11 unknown opcode no RAM access", ram_hits - hits0, 0);
      chk(got_data == 0 && !got_load, "R11 unknown opcode response", got_data, 0);
      chk(ram[15] == 32'h1133, "R11 unknown opcode leaves RAM", ram[15], 32'h1133);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) ram[i] = '0;
      exp_sp = 512;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_swap();
      t_fadd();
      t_push();
      t_pop();
      t_call_ret();
      t_busy_ignore();
      t_illegal();
      finish_run();
   end
endmodule